// File: doc/BRIEF.md
# GPIO Interrupt Detector and Status Latch

This block watches a bank of general-purpose input pins and turns level or edge activity on each of them into a latched, per-pin pending bit. Every pin owns a small configuration word (interrupt enable, status-latch enable, polarity, detection code), a one-bit pending status and a 3-bit routing field that names the processor meant to receive that pin's interrupt. Pins are passed through a two-flop synchronizer. Edges are found by comparing the current synchronized sample with the previous one.

Software acknowledges a pin by writing its status. A parameter selects whether a written 1 or a written 0 clears it. The single interrupt output is a registered OR over the pins that are enabled, routed to the local processor, and pending. A parameter selects either a 2-bit detection code, with a dedicated both-edges value, or a 1-bit code, where polarity picks the edge direction.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset all pending bits, configuration words, routing fields and the interrupt output are 0.
- R2: Pins pass through two synchronizer flops. For a pin change set up before rising edge n, the pending bit shows the event after edge n+2, and the interrupt output follows one edge later.
- R3: Configuration word layout: bit 0 interrupt enable, bit 1 status-latch enable, bit 2 polarity, bits starting at 3 the detection code. With a 2-bit code, 00 is level (polarity 1 high, 0 low), 01 is rising edge, 10 is falling edge and 11 is either edge.
- R4: With a 1-bit code, 1 selects edge detection and 0 selects level detection. Polarity 1 means rising or high, and polarity 0 means falling or low.
- R5: In level mode the pending bit is set on every cycle the level is active, so an acknowledge cannot clear it until the level has gone inactive.
- R6: While the status-latch enable bit is 0, a pin's pending bit never becomes set.
- R7: A pin whose interrupt enable is 0 still latches pending status, but it does not drive the interrupt output.
- R8: An acknowledge clears the addressed pending bit only when the written bit equals the ack polarity parameter (1 or 0). The other value has no effect. A new event in the same cycle wins over the acknowledge.
- R9: Only pins whose 3-bit routing field equals the local target parameter contribute to the interrupt output.
- R10: The interrupt output is registered. It is 1 on the cycle after some pin is enabled, locally routed and pending, and 0 on the cycle after none is.
- R11: Configuration, routing and acknowledge writes affect only the indexed pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Asynchronous pin levels |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_idx | input | IDX_W | Pin addressed by the configuration write |
| cfg_wdata | input | 3+DET_W | Configuration word |
| tgt_we | input | 1 | Routing field write strobe |
| tgt_idx | input | IDX_W | Pin addressed by the routing write |
| tgt_wdata | input | 3 | Routing field value |
| ack_we | input | 1 | Status acknowledge strobe |
| ack_idx | input | IDX_W | Pin addressed by the acknowledge |
| ack_wdata | input | 1 | Acknowledge data bit |
| status_o | output | NPINS | Pending status per pin |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The hardest case to reach is an acknowledge that lands in the same cycle as a fresh event, or while a level is still active. Only then does the set-over-clear priority decide the result. Random stimulus toggles pins slowly and issues acknowledges with random data to random pins on about a quarter of cycles, so these collisions occur many times. Two instances share the stimulus: one uses a 2-bit detection code with clear-on-1, and the other a 1-bit code with clear-on-0. The same configuration bits then mean different modes, and both are compared against a cycle model.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 8,
  parameter int DET_W = 2,
  parameter bit ACK_HIGH = 1'b1,
  parameter logic [2:0] LOCAL_TGT = 3'd4,
  localparam int CFG_W = 3 + DET_W,
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             tgt_we,
  input  logic [IDX_W-1:0] tgt_idx,
  input  logic [2:0]       tgt_wdata,
  input  logic             ack_we,
  input  logic [IDX_W-1:0] ack_idx,
  input  logic             ack_wdata,
  output logic [NPINS-1:0] status_o,
  output logic             irq_o
);

  logic [NPINS-1:0] meta_q, smp_q, prev_q, st_q, evt, pend;
  logic [CFG_W-1:0] cfg_q [NPINS];
  logic [2:0]       tgt_q [NPINS];
  logic             irq_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= '0;
      smp_q  <= '0;
      prev_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      meta_q <= pin_i;
      smp_q  <= meta_q;
      prev_q <= smp_q;
      irq_q  <= |pend;
    end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, lvl, pol, ack_hit;
    logic [DET_W-1:0] det;

    assign pol  = cfg_q[i][2];
    assign det  = cfg_q[i][3 +: DET_W];
    assign rise = smp_q[i] & ~prev_q[i];
    assign fall = ~smp_q[i] & prev_q[i];
    assign lvl  = pol ? smp_q[i] : ~smp_q[i];
    assign ack_hit = ack_we && (ack_idx == IDX_W'(i)) && (ack_wdata == ACK_HIGH);

    if (DET_W == 2) begin : g_det2
      always_comb
        case (det)
          2'b00:   evt[i] = lvl;
          2'b01:   evt[i] = rise;
          2'b10:   evt[i] = fall;
          default: evt[i] = rise | fall;
        endcase
    end else begin : g_det1
      assign evt[i] = det[0] ? (pol ? rise : fall) : lvl;
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cfg_q[i] <= '0;
        tgt_q[i] <= '0;
        st_q[i]  <= 1'b0;
      end else begin
        if (cfg_we && cfg_idx == IDX_W'(i)) cfg_q[i] <= cfg_wdata;
        if (tgt_we && tgt_idx == IDX_W'(i)) tgt_q[i] <= tgt_wdata;
        if (cfg_q[i][1] && evt[i]) st_q[i] <= 1'b1;
        else if (ack_hit)          st_q[i] <= 1'b0;
      end

    assign pend[i] = st_q[i] & cfg_q[i][0] & (tgt_q[i] == LOCAL_TGT);

    // R6
    raw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_q[i] && !cfg_q[i][1]) |=> !st_q[i]);

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && !(cfg_q[i][1] && evt[i])) |=> !st_q[i]);
  end

  assign status_o = st_q;
  assign irq_o    = irq_q;

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(|st_q));

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|st_q) |=> !irq_q);

endmodule

// File: tb/test_gpio_irq_detect.sv
`timescale 1ns/1ps
module test_gpio_irq_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pin_i = '0;
  logic cfg_we = 0, tgt_we = 0, ack_we = 0, ack_wdata = 0;
  logic [2:0] cfg_idx = 0, tgt_idx = 0, ack_idx = 0, tgt_wdata = 0;
  logic [4:0] cfg_wdata = 0;
  logic [7:0] st_a, st_b;
  logic irq_a, irq_b;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  gpio_irq_detect #(.NPINS(8), .DET_W(2), .ACK_HIGH(1'b1), .LOCAL_TGT(3'd4)) i_gpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .tgt_we(tgt_we), .tgt_idx(tgt_idx), .tgt_wdata(tgt_wdata),
    .ack_we(ack_we), .ack_idx(ack_idx), .ack_wdata(ack_wdata),
    .status_o(st_a), .irq_o(irq_a));

  gpio_irq_detect #(.NPINS(8), .DET_W(1), .ACK_HIGH(1'b0), .LOCAL_TGT(3'd4)) i_gpio_irq_detect_w1 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata[3:0]),
    .tgt_we(tgt_we), .tgt_idx(tgt_idx), .tgt_wdata(tgt_wdata),
    .ack_we(ack_we), .ack_idx(ack_idx), .ack_wdata(ack_wdata),
    .status_o(st_b), .irq_o(irq_b));

  // cycle model of both instances
  logic [4:0] m_cfg [8];
  logic [2:0] m_tgt [8];
  logic [7:0] m_s1, m_s2, m_p, m_sa, m_sb;
  logic m_ia, m_ib;

  function automatic logic ev(int w, logic [4:0] c, logic s, logic p);
    logic r, f, l;
    r = s & ~p; f = ~s & p; l = c[2] ? s : ~s;
    if (w == 2)
      case (c[4:3]) 2'b00: return l; 2'b01: return r; 2'b10: return f; default: return r | f; endcase
    return c[3] ? (c[2] ? r : f) : l;
  endfunction

  function automatic logic [7:0] pend(logic [7:0] st);
    logic [7:0] q;
    for (int i = 0; i < 8; i++) q[i] = st[i] & m_cfg[i][0] & (m_tgt[i] == 3'd4);
    return q;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin m_cfg[i] = '0; m_tgt[i] = '0; end
    m_s1 = 0; m_s2 = 0; m_p = 0; m_sa = 0; m_sb = 0; m_ia = 0; m_ib = 0;
  endtask

  task automatic step();
    logic [7:0] pin_c, na, nb;
    logic cw, tw, aw, ad;
    logic [2:0] ci, ti, ai, td;
    logic [4:0] cd;
    pin_c = pin_i; cw = cfg_we; ci = cfg_idx; cd = cfg_wdata;
    tw = tgt_we; ti = tgt_idx; td = tgt_wdata; aw = ack_we; ai = ack_idx; ad = ack_wdata;
    @(posedge clk);
    for (int i = 0; i < 8; i++) begin
      na[i] = (m_cfg[i][1] && ev(2, m_cfg[i], m_s2[i], m_p[i])) ? 1'b1 :
              (aw && ai == 3'(i) && ad == 1'b1) ? 1'b0 : m_sa[i];
      nb[i] = (m_cfg[i][1] && ev(1, m_cfg[i], m_s2[i], m_p[i])) ? 1'b1 :
              (aw && ai == 3'(i) && ad == 1'b0) ? 1'b0 : m_sb[i];
    end
    m_ia = |pend(m_sa); m_ib = |pend(m_sb);
    m_sa = na; m_sb = nb;
    m_p = m_s2; m_s2 = m_s1; m_s1 = pin_c;
    if (cw) m_cfg[ci] = cd;
    if (tw) m_tgt[ti] = td;
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_cfg(int idx, logic [4:0] d, logic [2:0] t);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_wdata = d;
    tgt_we = 1; tgt_idx = 3'(idx); tgt_wdata = t;
    step();
    cfg_we = 0; tgt_we = 0;
  endtask

  task automatic ack(int idx, logic d);
    ack_we = 1; ack_idx = 3'(idx); ack_wdata = d;
    step();
    ack_we = 0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status A", st_a, 8'h00); chk("R1 status B", st_b, 8'h00);
    chk("R1 irq", {6'd0, irq_a, irq_b}, 8'h00);

    // pin0 rising edge in both widths (A det01, B det1 pol1)
    wr_cfg(0, 5'h0F, 3'd4);
    pin_i[0] = 1; step(); step();
    chk("R2 not yet A", st_a, 8'h00); chk("R2 not yet B", st_b, 8'h00);
    step();
    chk("R3 rise A", st_a, 8'h01); chk("R4 rise B", st_b, 8'h01);
    chk("R10 irq one later", {6'd0, irq_a, irq_b}, 8'h00);
    step();
    chk("R10 irq set", {6'd0, irq_a, irq_b}, 8'h03);

    ack(0, 1'b1);
    chk("R8 ack1 A clears", st_a, 8'h00); chk("R8 ack1 B ignored", st_b, 8'h01);
    ack(0, 1'b0);
    chk("R8 ack0 B clears", st_b, 8'h00);
    chk("R10 irq A dropped", {7'd0, irq_a}, 8'h00);
    step();
    chk("R10 irq B dropped", {7'd0, irq_b}, 8'h00);

    // pin1 latch disabled
    wr_cfg(1, 5'h0D, 3'd4);
    pin_i[1] = 1; repeat (4) step();
    chk("R6 no latch A", st_a, 8'h00); chk("R6 no latch B", st_b, 8'h00);

    // pin2 latched but not enabled
    wr_cfg(2, 5'h0E, 3'd4);
    pin_i[2] = 1; repeat (4) step();
    chk("R7 latched A", st_a, 8'h04); chk("R7 latched B", st_b, 8'h04);
    chk("R7 no irq", {6'd0, irq_a, irq_b}, 8'h00);

    // pin3 enabled but routed elsewhere
    wr_cfg(3, 5'h0F, 3'd1);
    pin_i[3] = 1; repeat (4) step();
    chk("R9 status A", st_a, 8'h0C); chk("R11 pin2 kept B", st_b, 8'h0C);
    chk("R9 no irq", {6'd0, irq_a, irq_b}, 8'h00);
    for (int i = 2; i < 4; i++) begin ack(i, 1'b1); ack(i, 1'b0); end
    chk("R11 acks cleared A", st_a, 8'h00); chk("R11 acks cleared B", st_b, 8'h00);

    // pin4 level-high
    wr_cfg(4, 5'h07, 3'd4);
    pin_i[4] = 1; repeat (3) step();
    chk("R5 level A", st_a, 8'h10); chk("R5 level B", st_b, 8'h10);
    ack(4, 1'b1); ack(4, 1'b0);
    chk("R5 held A", st_a, 8'h10); chk("R5 held B", st_b, 8'h10);
    pin_i[4] = 0; repeat (3) step();
    ack(4, 1'b1); ack(4, 1'b0);
    chk("R5 cleared A", st_a, 8'h00); chk("R5 cleared B", st_b, 8'h00);

    // random phase against model
    for (int n = 0; n < 4000; n++) begin
      for (int b = 0; b < 8; b++) if ($urandom_range(0, 9) == 0) pin_i[b] = ~pin_i[b];
      cfg_we = ($urandom_range(0, 7) == 0); cfg_idx = 3'($urandom_range(0, 7));
      cfg_wdata = 5'($urandom_range(0, 31)) | 5'h02;
      if ($urandom_range(0, 7) == 0) cfg_wdata[1] = 1'b0;
      tgt_we = ($urandom_range(0, 7) == 0); tgt_idx = 3'($urandom_range(0, 7));
      tgt_wdata = ($urandom_range(0, 2) == 0) ? 3'($urandom_range(0, 7)) : 3'd4;
      ack_we = ($urandom_range(0, 3) == 0); ack_idx = 3'($urandom_range(0, 7));
      ack_wdata = 1'($urandom_range(0, 1));
      step();
      chk("R3/R11 status A", st_a, m_sa); chk("R4/R11 status B", st_b, m_sb);
      chk("R10 irq A", {7'd0, irq_a}, {7'd0, m_ia}); chk("R9 irq B", {7'd0, irq_b}, {7'd0, m_ib});
    end
    cfg_we = 0; tgt_we = 0; ack_we = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule